// File: doc/BRIEF.md
# Ring Drain Address Unit

This unit drives the read side of a FIFO ring buffer kept in memory. A producer channel fills the ring and moves a write pointer forward. This unit drains the ring on behalf of a consumer channel. The ring is described by a base address and a mask, and it ends at an exclusive top of base + mask + 16 bytes. All addresses are 16-byte quadword aligned.

A command gives a start address and a quadword count. If the start address lies inside the ring, the unit works out how many quadwords sit between the read pointer and the live producer pointer. It grants the smaller of that amount and what is still owed. If the granted burst runs past the top of the ring, the unit issues it as two segments, and the second one restarts at the ring base. If nothing is available, it raises an empty flag and waits. If the start address lies outside the ring, the whole count is issued in one segment with no checks. Each segment goes out as an address and a 32-bit word count on a valid/ready handshake.

Top module: `drain_ring_unit`

## Requirements
- R1: While reset is held and just after it, `cmd_ready` is 1, `seg_valid` is 0 and `empty` is 0.
- R2: When the read address is inside the ring and at or below `prod_addr`, availability is (prod − read)/16 quadwords. The grant is min(owed, available), and a grant that does not pass the top is issued as one segment at the read address with `seg_words` = 4 × grant.
- R3: When the read address is above `prod_addr`, availability is ((prod − base) + (top − read))/16 quadwords.
- R4: When read + 16 × grant is greater than the top, the first segment carries (top − read)/4 words at the read address with `seg_wrapped`=0. The second carries the remaining words at `ring_base` with `seg_wrapped`=1. A burst that ends exactly at the top is not split.
- R5: After each accepted segment, an in-ring read address moves forward by 4 × `seg_words` bytes and is re-wrapped to base + (address AND mask), so a pointer that reaches the top continues at the base.
- R6: With zero quadwords available and some still owed, no segment is issued and `empty` goes to 1. It returns to 0 and issuing resumes once the producer pointer makes data available.
- R7: A start address outside [base, top) is issued as a single segment of 4 × count words at that address, whatever the producer pointer says.
- R8: A command whose count exceeds the current availability goes on issuing further grants until the full count has been delivered. Only then does `cmd_ready` return to 1.
- R9: A command with a count of zero issues no segment and returns to ready.
- R10: While `seg_valid` is 1 and `seg_ready` is 0, the segment address, word count and wrapped flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Ring base address, aligned to the ring size |
| ring_mask | input | ADDR_W | Ring mask, ring size minus 16 |
| prod_addr | input | ADDR_W | Live producer write address |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit idle, command accepted |
| cmd_addr | input | ADDR_W | Command start read address |
| cmd_qwc | input | QW_W | Command quadword count |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment taken |
| seg_addr | output | ADDR_W | Segment start address |
| seg_words | output | QW_W+2 | Segment length in 32-bit words |
| seg_wrapped | output | 1 | Segment is the part after the ring top |
| empty | output | 1 | Waiting on an empty ring |

## Verification
The hardest case to reach is a single command that stalls on an empty ring more than once. In that case the producer pointer has to move between grants, and at one point it falls below the read pointer, so the next grant uses the wrapped availability formula. The stimulus gets there by queuing producer positions that the bench applies only when it sees `empty` rise. The reference model then works out each new grant from the producer value that was live at that moment. Bursts that end one quadword past the top and bursts that end exactly at the top are both driven, with and without consumer backpressure.

// File: rtl/drain_ring_pkg.sv
package drain_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ISSUE = 2'd2
  } drain_state_e;
endpackage

// File: rtl/drain_avail.sv
// Ring geometry and quadword availability between read and producer pointers.
module drain_avail #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] rd,
  input  logic [ADDR_W-1:0] prod,
  output logic [ADDR_W-1:0] top,
  output logic              in_ring,
  output logic [ADDR_W-1:0] avail
);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(16);

  always_comb begin
    top     = base + mask + QW_BYTES;
    in_ring = (rd >= base) && (rd < top);
    if (rd <= prod) avail = (prod - rd) >> 4;
    else            avail = ((prod - base) + (top - rd)) >> 4;
  end
endmodule

// File: rtl/drain_seg_plan.sv
// Grant sizing and split of a burst at the ring top.
module drain_seg_plan #(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 16,
  parameter int WD_W   = QW_W + 2
) (
  input  logic [ADDR_W-1:0] rd,
  input  logic [ADDR_W-1:0] top,
  input  logic [QW_W-1:0]   rem,
  input  logic [ADDR_W-1:0] avail,
  input  logic              in_ring,
  output logic [WD_W-1:0]   head_words,
  output logic [WD_W-1:0]   tail_words
);
  logic [QW_W-1:0]   grant;
  logic [ADDR_W:0]   span_end;
  logic [WD_W-1:0]   grant_words;
  logic [WD_W-1:0]   to_top_words;
  logic              split;

  always_comb begin
    if (!in_ring)                                        grant = rem;
    else if (avail < {{(ADDR_W-QW_W){1'b0}}, rem})       grant = avail[QW_W-1:0];
    else                                                 grant = rem;
    span_end     = {1'b0, rd} + ({{(ADDR_W+1-QW_W){1'b0}}, grant} << 4);
    grant_words  = {grant, 2'b00};
    to_top_words = WD_W'((top - rd) >> 2);
    split        = in_ring && (span_end > {1'b0, top});
    head_words   = split ? to_top_words : grant_words;
    tail_words   = split ? (grant_words - to_top_words) : '0;
  end
endmodule

// File: rtl/drain_ring_unit.sv
module drain_ring_unit
  import drain_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [ADDR_W-1:0] ring_mask,
  input  logic [ADDR_W-1:0] prod_addr,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [QW_W-1:0]   cmd_qwc,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [QW_W+1:0]   seg_words,
  output logic              seg_wrapped,
  output logic              empty
);
  localparam int WD_W = QW_W + 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  drain_state_e          state_q, state_d;
  logic [ADDR_W-1:0]     rd_q, rd_d;
  logic [QW_W-1:0]       rem_q, rem_d, rem_after;
  logic [WD_W-1:0]       segw_q, segw_d, pend_q, pend_d;
  logic                  wrapd_q, wrapd_d, empty_q, empty_d;
  logic                  upd_en;

  logic [ADDR_W-1:0]     top, avail, adv, adv_wrap;
  logic                  in_ring;
  logic [WD_W-1:0]       head_w, tail_w;

  drain_avail #(.ADDR_W(ADDR_W)) u_avail (
    .base(ring_base), .mask(ring_mask), .rd(rd_q), .prod(prod_addr),
    .top(top), .in_ring(in_ring), .avail(avail)
  );

  drain_seg_plan #(.ADDR_W(ADDR_W), .QW_W(QW_W), .WD_W(WD_W)) u_plan (
    .rd(rd_q), .top(top), .rem(rem_q), .avail(avail), .in_ring(in_ring),
    .head_words(head_w), .tail_words(tail_w)
  );

  always_comb begin
    adv       = rd_q + ({{(ADDR_W-WD_W){1'b0}}, segw_q} << 2);
    adv_wrap  = ring_base + (adv & ring_mask);
    rem_after = rem_q - segw_q[WD_W-1:2];
  end

  // next state
  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    rem_d   = rem_q;
    segw_d  = segw_q;
    pend_d  = pend_q;
    wrapd_d = wrapd_q;
    empty_d = empty_q;
    upd_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        empty_d = 1'b0;
        if (cmd_valid) begin
          upd_en  = 1'b1;
          rd_d    = cmd_addr;
          rem_d   = cmd_qwc;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        upd_en = 1'b1;
        if (rem_q == '0) begin
          empty_d = 1'b0;
          state_d = ST_IDLE;
        end else if (in_ring && (avail == '0)) begin
          empty_d = 1'b1;
        end else begin
          empty_d = 1'b0;
          segw_d  = head_w;
          pend_d  = tail_w;
          wrapd_d = 1'b0;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (seg_ready) begin
          upd_en = 1'b1;
          rd_d   = in_ring ? adv_wrap : adv;
          rem_d  = rem_after;
          if (pend_q != '0) begin
            segw_d  = pend_q;
            pend_d  = '0;
            wrapd_d = 1'b1;
          end else begin
            state_d = (rem_after == '0) ? ST_IDLE : ST_EVAL;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      rd_q    <= '0;
      rem_q   <= '0;
      segw_q  <= '0;
      pend_q  <= '0;
      wrapd_q <= 1'b0;
      empty_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      rd_q    <= rd_d;
      rem_q   <= rem_d;
      segw_q  <= segw_d;
      pend_q  <= pend_d;
      wrapd_q <= wrapd_d;
      empty_q <= empty_d;
    end
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign seg_valid   = (state_q == ST_ISSUE);
  assign seg_addr    = rd_q;
  assign seg_words   = segw_q;
  assign seg_wrapped = wrapd_q;
  assign empty       = empty_q;
endmodule

// File: rtl/drain_ring_chk.sv
module drain_ring_chk #(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ring_base,
  input logic              cmd_ready,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [QW_W+1:0]   seg_words,
  input logic              seg_wrapped,
  input logic              empty
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!seg_valid && !empty));

  p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_words != '0));

  p_second_at_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_wrapped) |-> (seg_addr == ring_base));

  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !seg_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr)
                                   && $stable(seg_words) && $stable(seg_wrapped)));
endmodule

bind drain_ring_unit drain_ring_chk #(.ADDR_W(ADDR_W), .QW_W(QW_W)) u_chk (.*);

// File: tb/drain_ring_unit_tb.sv
`timescale 1ns/1ps
module drain_ring_unit_tb_top;
  localparam int AW = 32;
  localparam int QW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ring_base, ring_mask, prod_addr, cmd_addr, seg_addr;
  logic          cmd_valid, cmd_ready, seg_valid, seg_ready, seg_wrapped, empty;
  logic [QW-1:0] cmd_qwc;
  logic [QW+1:0] seg_words;

  always #2.5 clk = ~clk;

  drain_ring_unit #(.ADDR_W(AW), .QW_W(QW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_mask(ring_mask),
    .prod_addr(prod_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_qwc(cmd_qwc), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_words(seg_words),
    .seg_wrapped(seg_wrapped), .empty(empty)
  );

  int     n_chk = 0, n_bad = 0;
  bit     finished = 0;
  longint r_base = 64'h1000, r_mask = 64'h00F0, r_top;
  longint m_rd, m_rem, m_pend, e_addr, e_words;
  bit     e_wrap, have_exp, prev_empty, bp_mode;
  int     segs;
  longint refill_q[$];

  function automatic bit in_ring(longint a);
    return (a >= r_base) && (a < r_top);
  endfunction
  function automatic longint avail_of(longint rd, longint p);
    if (rd <= p) return (p - rd) / 16;
    return ((p - r_base) + (r_top - rd)) / 16;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference: next expected segment from model state and live producer
  task automatic plan_next();
    longint g;
    if (m_pend > 0) begin
      e_words = m_pend; m_pend = 0; e_wrap = 1;
    end else begin
      e_wrap = 0;
      if (in_ring(m_rd)) begin
        g = avail_of(m_rd, longint'(prod_addr));
        if (g > m_rem) g = m_rem;
        if (m_rd + g * 16 > r_top) begin
          e_words = (r_top - m_rd) / 4;
          m_pend  = g * 4 - e_words;
        end else e_words = g * 4;
      end else e_words = m_rem * 4;
    end
    e_addr = m_rd;
    have_exp = 1;
  endtask

  task automatic run_cmd(longint a, longint q, longint p0, int exp_segs, string tag);
    bit ring_now;
    @(negedge clk);
    check(cmd_ready == 1'b1, tag, "ready before command", longint'(cmd_ready), 1);
    prod_addr = AW'(p0); cmd_addr = AW'(a); cmd_qwc = QW'(q); cmd_valid = 1'b1;
    m_rd = a; m_rem = q; m_pend = 0; have_exp = 0; segs = 0; prev_empty = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (cmd_ready) break;
      seg_ready = bp_mode ? ((i % 3) == 2) : 1'b1;
      if (empty && !prev_empty) begin
        check(in_ring(m_rd) && avail_of(m_rd, longint'(prod_addr)) == 0
              && m_pend == 0 && !seg_valid, "R6", "empty raised", longint'(m_rd),
              longint'(prod_addr));
        if (refill_q.size() > 0) prod_addr = AW'(refill_q.pop_front());
      end
      prev_empty = empty;
      if (seg_valid) begin
        if (!have_exp) plan_next();
        check(longint'(seg_addr) == e_addr, tag, "seg_addr", longint'(seg_addr), e_addr);
        check(longint'(seg_words) == e_words, tag, "seg_words", longint'(seg_words), e_words);
        check(seg_wrapped == e_wrap, tag, "seg_wrapped", longint'(seg_wrapped), longint'(e_wrap));
        check(empty == 1'b0, "R6", "empty with segment", longint'(empty), 0);
        if (seg_ready) begin
          ring_now = in_ring(m_rd);
          m_rd  = m_rd + e_words * 4;
          if (ring_now) m_rd = r_base + (m_rd & r_mask);
          m_rem = m_rem - e_words / 4;
          have_exp = 0;
          segs++;
        end
      end
      @(negedge clk);
    end
    seg_ready = 1'b1;
    check(cmd_ready == 1'b1 && m_rem == 0, "R8", "command completion", m_rem, 0);
    check(segs == exp_segs, tag, "segment count", segs, exp_segs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    summary();
  end

  initial begin
    r_top = r_base + r_mask + 16;
    ring_base = AW'(r_base); ring_mask = AW'(r_mask);
    prod_addr = '0; cmd_addr = '0; cmd_qwc = '0; cmd_valid = 1'b0;
    seg_ready = 1'b1; bp_mode = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "cmd_ready in reset", longint'(cmd_ready), 1);
    check(seg_valid == 1'b0, "R1", "seg_valid in reset", longint'(seg_valid), 0);
    check(empty == 1'b0, "R1", "empty in reset", longint'(empty), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready == 1'b1 && !seg_valid && !empty, "R1", "idle after reset",
          longint'(seg_valid), 0);

    // R2: plain grant, limited by request
    run_cmd(64'h1000, 4, 64'h1080, 1, "R2");
    // R2: grant limited by availability, then continues (R8) with R3 wrap formula
    refill_q = {64'h10C0, 64'h1020};
    run_cmd(64'h1040, 10, 64'h1080, 3, "R3");
    // R4: split across the top, R3 availability
    run_cmd(64'h10C0, 6, 64'h1040, 2, "R4");
    // R4: last quadword before top, split into 4 + 4 words
    run_cmd(64'h10F0, 2, 64'h1010, 2, "R4");
    // R5: burst ends exactly at top, no split, next grant at base after empty
    refill_q = {64'h1020};
    run_cmd(64'h10C0, 6, 64'h1000, 2, "R5");
    // R7: outside the ring
    run_cmd(64'h8000, 3, 64'h1000, 1, "R7");
    // R9: zero count
    run_cmd(64'h1000, 0, 64'h1080, 0, "R9");
    // R10: backpressure during split and plain segments
    bp_mode = 1;
    run_cmd(64'h10C0, 8, 64'h1040, 2, "R10");
    run_cmd(64'h1000, 2, 64'h1080, 1, "R10");
    bp_mode = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule